// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block runs automatic round-robin conversions over a set of input channels. A programmable scan list names which physical channel is converted in each slot, and an active-slot count says how many slots make up one scan. Every channel carries its own gain code, polarity and calibration mode. When a slot comes up, the sequencer registers that channel's settings, offers them to an external converter through a request handshake and then waits for the converter's completion strobe with a 16-bit result.

Each result is written into a result memory indexed by slot. The slot number appears on a logical-channel output. A one-cycle pulse marks each completed conversion. An active-low end-of-scan flag stays low from the end of a scan until the host reads the result of the scan's final slot. A calibration indicator shows whether any channel in the active scan is set to a calibration mode. The host reaches configuration and results through a simple register bus. Reads return data one cycle after the read strobe.

Converter request rules: `conv_start_valid` stays high, with channel, gain, polarity and calibration fields unchanged, until the cycle in which `conv_start_ready` is high. The sequencer never applies back-pressure to `conv_done`. A strobe is taken in any cycle after the request was accepted.

Top module: `scan_sequencer`

## Requirements
- R1: After `rst_n` low, `eos_n` is 1, `mxc` is 0, `lchan` is 0, `conv_start_valid` is 0, `cal_active` is 0, every result reads 0, and the control word reads active-count-minus-one = 7 with the enable bit (bit 8) clear.
- R2: Each scan requests slots 0 up to the programmed last slot in order. The request channel is the scan-list entry for that slot (list region, address `{2'b01, slot}`, bits [2:0]), and `lchan` shows the slot.
- R3: With each request, `conv_gain`, `conv_bipolar` and `conv_cal` equal the requested channel's settings (config region `{2'b00, ch}`: bits [2:0] gain code, where gain = code+1; bit 3 bipolar; bits [5:4] calibration mode, nonzero meaning calibration).
- R4: While `conv_start_ready` is low, `conv_start_valid` stays high and the request fields stay unchanged. After acceptance, `conv_start_valid` is low until the conversion completes.
- R5: A result taken on `conv_done` is stored for its slot and reads back from the result region `{2'b11, slot}`, with `bus_rvalid` high in the cycle after `bus_rd`.
- R6: `mxc` is high for exactly one cycle: the second cycle after the cycle in which `conv_done` was taken.
- R7: The next request is valid in the cycle right after a completion. After the last slot, with enable set, the next request is slot 0.
- R8: `eos_n` goes low when the last slot of a scan completes. Only a read of that scan's last-slot result raises it, and reads of other slots leave it low.
- R9: When another scan completes before that read, its results overwrite the stored ones and `eos_n` stays low.
- R10: A write to the control word (address `{2'b10, x}`: bits [2:0] last slot, bit 8 enable) or to the scan list during a scan changes the slot count and order only from the next scan on.
- R11: `cal_active` is 1 exactly when some slot at or below the current last slot names a channel whose calibration mode is nonzero.
- R12: Once enable is clear at the end of a scan, the sequencer stops and issues no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Region (bits 4:3) and index (bits 2:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| conv_start_valid | output | 1 | Conversion request pending |
| conv_start_ready | input | 1 | Converter accepts the request |
| conv_chan | output | 3 | Physical channel to convert |
| conv_gain | output | 3 | Gain code (gain = code+1) |
| conv_bipolar | output | 1 | 1 = bipolar, 0 = unipolar |
| conv_cal | output | 2 | Calibration mode of the channel |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | 16 | Result, valid with `conv_done` |
| lchan | output | 3 | Slot being converted |
| mxc | output | 1 | One-cycle conversion-complete pulse |
| eos_n | output | 1 | End of scan, active low |
| cal_active | output | 1 | Some active channel is in calibration |

## Verification
The bench builds the block with its default parameters: 3 channel-index bits (eight channels, eight slots) and 16-bit results. At this size it can sweep every active-slot count from one to eight, each with its own permuted scan order and computed result values. That sweep places the slot wrap at every possible position and writes every entry of the result memory. The small size also leaves room for multi-scan runs that cover overwrites before a host read, mid-scan reprogramming and the calibration OR.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic [1:0] cal;
    logic       bipolar;
    logic [2:0] gain;
  } ch_cfg_t;

  localparam logic [1:0] RGN_CFG  = 2'd0;
  localparam logic [1:0] RGN_LIST = 2'd1;
  localparam logic [1:0] RGN_CTRL = 2'd2;
  localparam logic [1:0] RGN_RES  = 2'd3;

  localparam int ENA_BIT = 8;

endpackage

// File: rtl/scanseq_regs.sv
module scanseq_regs
  import scanseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 16,
  localparam int NUM_CH = 1 << CH_W,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [RES_W-1:0]                bus_wdata,
  output logic [RES_W-1:0]                bus_rdata,
  output logic                            bus_rvalid,
  input  logic [RES_W-1:0]                res_rd_data,
  output logic [CH_W-1:0]                 res_rd_idx,
  output logic                            res_rd_hit,
  output ch_cfg_t [NUM_CH-1:0]            cfg_o,
  output logic [NUM_CH-1:0][CH_W-1:0]     list_o,
  output logic [CH_W-1:0]                 cnt_m1_o,
  output logic                            enable_o
);

  logic [1:0]                     rgn;
  logic [CH_W-1:0]                idx;
  ch_cfg_t [NUM_CH-1:0]           cfg_q;
  logic [NUM_CH-1:0][CH_W-1:0]    list_q;
  logic [CH_W-1:0]                cnt_q;
  logic                           en_q;
  logic [RES_W-1:0]               rdata_q;
  logic                           rvalid_q;
  logic                           wdata_unused;

  assign rgn          = bus_addr[ADDR_W-1:CH_W];
  assign idx          = bus_addr[CH_W-1:0];
  assign wdata_unused = ^bus_wdata;

  // configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        cfg_q[i]  <= '0;
        list_q[i] <= CH_W'(i);
      end
      cnt_q <= '1;
      en_q  <= 1'b0;
    end else if (bus_wr) begin
      case (rgn)
        RGN_CFG:  cfg_q[idx]  <= ch_cfg_t'(bus_wdata[5:0]);
        RGN_LIST: list_q[idx] <= bus_wdata[CH_W-1:0];
        RGN_CTRL: begin
          cnt_q <= bus_wdata[CH_W-1:0];
          en_q  <= bus_wdata[ENA_BIT];
        end
        default: ;
      endcase
    end
  end

  // registered read path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        rdata_q <= '0;
        case (rgn)
          RGN_CFG:  rdata_q[5:0]      <= cfg_q[idx];
          RGN_LIST: rdata_q[CH_W-1:0] <= list_q[idx];
          RGN_CTRL: begin
            rdata_q[CH_W-1:0] <= cnt_q;
            rdata_q[ENA_BIT]  <= en_q;
          end
          default:  rdata_q <= res_rd_data;
        endcase
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign res_rd_idx = idx;
  assign res_rd_hit = bus_rd && (rgn == RGN_RES);
  assign cfg_o      = cfg_q;
  assign list_o     = list_q;
  assign cnt_m1_o   = cnt_q;
  assign enable_o   = en_q;

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R5

endmodule

// File: rtl/scanseq_ram.sv
module scanseq_ram #(
  parameter int CH_W  = 3,
  parameter int RES_W = 16,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [RES_W-1:0] rd_data
);

  logic [NUM_CH-1:0][RES_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
  import scanseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 16,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ch_cfg_t [NUM_CH-1:0]         cfg_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]  list_i,
  input  logic [CH_W-1:0]              cnt_m1_i,
  input  logic                         enable_i,
  output logic                         conv_start_valid,
  input  logic                         conv_start_ready,
  output logic [CH_W-1:0]              conv_chan,
  output logic [2:0]                   conv_gain,
  output logic                         conv_bipolar,
  output logic [1:0]                   conv_cal,
  input  logic                         conv_done,
  input  logic [RES_W-1:0]             conv_result,
  output logic                         wr_en,
  output logic [CH_W-1:0]              wr_idx,
  output logic [RES_W-1:0]             wr_data,
  output logic [CH_W-1:0]              slot_o,
  output logic                         mxc_o,
  output logic                         scan_end_o,
  output logic [CH_W-1:0]              sh_cnt_o,
  output logic [NUM_CH-1:0][CH_W-1:0]  sh_list_o
);

  scan_state_e                  state_q;
  logic [CH_W-1:0]              slot_q;
  logic [CH_W-1:0]              slot_nx;
  logic [CH_W-1:0]              sh_cnt_q;
  logic [NUM_CH-1:0][CH_W-1:0]  sh_list_q;
  logic                         done_acc;
  logic                         last_slot;
  logic                         ld_en;
  logic [CH_W-1:0]              ld_chan;
  logic                         done_cap_q;
  logic                         mxc_q;
  logic [CH_W-1:0]              chan_q;
  ch_cfg_t                      set_q;

  assign slot_nx    = slot_q + CH_W'(1);
  assign done_acc   = (state_q == ST_WAIT) && conv_done;
  assign last_slot  = (slot_q == sh_cnt_q);
  assign scan_end_o = done_acc && last_slot;

  // which channel's settings to register for the next request
  always_comb begin
    ld_en   = 1'b0;
    ld_chan = list_i[0];
    case (state_q)
      ST_IDLE: ld_en = enable_i;
      ST_WAIT: begin
        if (conv_done) begin
          if (last_slot) begin
            ld_en = enable_i;
          end else begin
            ld_en   = 1'b1;
            ld_chan = sh_list_q[slot_nx];
          end
        end
      end
      default: ;
    endcase
  end

  // scan state machine with per-scan shadow of count and order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      sh_cnt_q  <= '0;
      sh_list_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sh_list_q <= list_i;
          sh_cnt_q  <= cnt_m1_i;
          slot_q    <= '0;
          if (enable_i) state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (conv_start_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (last_slot) begin
              slot_q <= '0;
              if (enable_i) begin
                sh_list_q <= list_i;
                sh_cnt_q  <= cnt_m1_i;
                state_q   <= ST_REQ;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              slot_q  <= slot_nx;
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // request fields, frozen while the request is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      set_q  <= '0;
    end else if (ld_en) begin
      chan_q <= ld_chan;
      set_q  <= cfg_i[ld_chan];
    end
  end

  // completion pulse: captured, then issued one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_cap_q <= 1'b0;
      mxc_q      <= 1'b0;
    end else begin
      done_cap_q <= done_acc;
      mxc_q      <= done_cap_q;
    end
  end

  assign conv_start_valid = (state_q == ST_REQ);
  assign conv_chan        = chan_q;
  assign conv_gain        = set_q.gain;
  assign conv_bipolar     = set_q.bipolar;
  assign conv_cal         = set_q.cal;
  assign wr_en            = done_acc;
  assign wr_idx           = slot_q;
  assign wr_data          = conv_result;
  assign slot_o           = slot_q;
  assign mxc_o            = mxc_q;
  assign sh_cnt_o         = sh_cnt_q;
  assign sh_list_o        = sh_list_q;

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_valid && !conv_start_ready |=> conv_start_valid && $stable(conv_chan) && $stable(conv_gain) && $stable(conv_bipolar) && $stable(conv_cal)); // R4
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o <= sh_cnt_q); // R2
  AST_MXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mxc_o |=> !mxc_o); // R6
  AST_MXC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> ##1 mxc_o); // R6
  AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc && !last_slot |=> conv_start_valid); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end_o |=> slot_o == '0); // R7
  AST_PLAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && !scan_end_o |=> $stable(sh_cnt_q) && $stable(sh_list_q)); // R10

endmodule

// File: rtl/scanseq_status.sv
module scanseq_status
  import scanseq_pkg::*;
#(
  parameter int CH_W = 3,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ch_cfg_t [NUM_CH-1:0]         cfg_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]  sh_list_i,
  input  logic [CH_W-1:0]              sh_cnt_i,
  input  logic                         scan_end_i,
  input  logic                         res_rd_hit,
  input  logic [CH_W-1:0]              res_rd_idx,
  output logic                         eos_n_o,
  output logic                         cal_active_o
);

  logic            eos_n_q;
  logic [CH_W-1:0] eos_last_q;
  logic            release_hit;
  logic            cal_any;
  logic            cal_q;
  logic            cfg_unused;

  assign release_hit = res_rd_hit && (res_rd_idx == eos_last_q);
  assign cfg_unused  = ^cfg_i;

  // a completion in the same cycle as the releasing read wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_n_q    <= 1'b1;
      eos_last_q <= '0;
    end else if (scan_end_i) begin
      eos_n_q    <= 1'b0;
      eos_last_q <= sh_cnt_i;
    end else if (release_hit) begin
      eos_n_q <= 1'b1;
    end
  end

  always_comb begin
    cal_any = 1'b0;
    for (int s = 0; s < NUM_CH; s++) begin
      if ((CH_W'(s) <= sh_cnt_i) && (cfg_i[sh_list_i[s]].cal != 2'b00)) cal_any = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= 1'b0;
    else        cal_q <= cal_any;
  end

  assign eos_n_o      = eos_n_q;
  assign cal_active_o = cal_q;

  AST_EOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eos_n_o && !release_hit |=> !eos_n_o); // R8
  AST_EOS_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end_i |=> !eos_n_o); // R9

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scanseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 16,
  localparam int NUM_CH = 1 << CH_W,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RES_W-1:0]  bus_wdata,
  output logic [RES_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              conv_start_valid,
  input  logic              conv_start_ready,
  output logic [CH_W-1:0]   conv_chan,
  output logic [2:0]        conv_gain,
  output logic              conv_bipolar,
  output logic [1:0]        conv_cal,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [CH_W-1:0]   lchan,
  output logic              mxc,
  output logic              eos_n,
  output logic              cal_active
);

  ch_cfg_t [NUM_CH-1:0]         cfg;
  logic [NUM_CH-1:0][CH_W-1:0]  list;
  logic [NUM_CH-1:0][CH_W-1:0]  sh_list;
  logic [CH_W-1:0]              cnt_m1;
  logic [CH_W-1:0]              sh_cnt;
  logic                         enable;
  logic                         wr_en;
  logic [CH_W-1:0]              wr_idx;
  logic [RES_W-1:0]             wr_data;
  logic [CH_W-1:0]              rd_idx;
  logic [RES_W-1:0]             rd_data;
  logic                         rd_hit;
  logic                         scan_end;

  scanseq_regs #(.CH_W(CH_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .res_rd_data(rd_data), .res_rd_idx(rd_idx), .res_rd_hit(rd_hit),
    .cfg_o(cfg), .list_o(list), .cnt_m1_o(cnt_m1), .enable_o(enable)
  );

  scanseq_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_i(cfg), .list_i(list), .cnt_m1_i(cnt_m1), .enable_i(enable),
    .conv_start_valid(conv_start_valid), .conv_start_ready(conv_start_ready),
    .conv_chan(conv_chan), .conv_gain(conv_gain), .conv_bipolar(conv_bipolar), .conv_cal(conv_cal),
    .conv_done(conv_done), .conv_result(conv_result),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .slot_o(lchan), .mxc_o(mxc), .scan_end_o(scan_end),
    .sh_cnt_o(sh_cnt), .sh_list_o(sh_list)
  );

  scanseq_ram #(.CH_W(CH_W), .RES_W(RES_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  scanseq_status #(.CH_W(CH_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .cfg_i(cfg), .sh_list_i(sh_list), .sh_cnt_i(sh_cnt),
    .scan_end_i(scan_end), .res_rd_hit(rd_hit), .res_rd_idx(rd_idx),
    .eos_n_o(eos_n), .cal_active_o(cal_active)
  );

endmodule

// File: tb/sim_scan_sequencer.sv
module sim_scan_sequencer;

  localparam int CH_W  = 3;
  localparam int RES_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [CH_W+1:0]   bus_addr = '0;
  logic [RES_W-1:0]  bus_wdata = '0;
  logic [RES_W-1:0]  bus_rdata;
  logic              bus_rvalid;
  logic              conv_start_valid;
  logic              conv_start_ready = 1'b0;
  logic [CH_W-1:0]   conv_chan;
  logic [2:0]        conv_gain;
  logic              conv_bipolar;
  logic [1:0]        conv_cal;
  logic              conv_done = 1'b0;
  logic [RES_W-1:0]  conv_result = '0;
  logic [CH_W-1:0]   lchan;
  logic              mxc, eos_n, cal_active;

  int checks = 0;
  int fails  = 0;
  int gcode[8];
  int bip[8];
  int calc[8];

  always #5 clk = ~clk;

  scan_sequencer #(.CH_W(CH_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .conv_start_valid(conv_start_valid), .conv_start_ready(conv_start_ready),
    .conv_chan(conv_chan), .conv_gain(conv_gain), .conv_bipolar(conv_bipolar), .conv_cal(conv_cal),
    .conv_done(conv_done), .conv_result(conv_result),
    .lchan(lchan), .mxc(mxc), .eos_n(eos_n), .cal_active(cal_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int adr(input int rgn, input int idx);
    return rgn * 8 + idx;
  endfunction

  function automatic int resval(input int tag, input int slot, input int ch);
    return (tag * 4099 + slot * 257 + ch * 17 + 3) & 16'hFFFF;
  endfunction

  task automatic bwrite(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[CH_W+1:0]; bus_wdata = d[RES_W-1:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[CH_W+1:0];
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
    chk("R5", "read valid", int'(bus_rvalid), 1);
  endtask

  task automatic wr_cfg(input int ch);
    bwrite(adr(0, ch), calc[ch] * 16 + bip[ch] * 8 + gcode[ch]);
  endtask

  // converter model: checks the request, applies back-pressure, returns a result
  task automatic convert(input int slot, input int ch, input int val, input int hold, input int more);
    int t = 0;
    @(negedge clk);
    while (!conv_start_valid && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk("R2", "request channel", int'(conv_chan), ch);
    chk("R2", "logical channel", int'(lchan), slot);
    chk("R3", "gain code", int'(conv_gain), gcode[ch]);
    chk("R3", "polarity", int'(conv_bipolar), bip[ch]);
    chk("R3", "cal mode", int'(conv_cal), calc[ch]);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R4", "valid held", int'(conv_start_valid), 1);
      chk("R4", "channel held", int'(conv_chan), ch);
    end
    conv_start_ready = 1'b1;
    @(negedge clk);
    conv_start_ready = 1'b0;
    chk("R4", "valid after accept", int'(conv_start_valid), 0);
    repeat (2) @(negedge clk);
    conv_done = 1'b1; conv_result = val[RES_W-1:0];
    @(negedge clk);
    conv_done = 1'b0;
    chk("R6", "mxc not yet", int'(mxc), 0);
    chk("R7", "next request without gap", int'(conv_start_valid), more);
    @(negedge clk);
    chk("R6", "mxc pulse", int'(mxc), 1);
    @(negedge clk);
    chk("R6", "mxc one cycle", int'(mxc), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d;
    int ch;
    int lst[8];
    for (int c = 0; c < 8; c++) begin
      gcode[c] = 7 - c;
      bip[c]   = c & 1;
      calc[c]  = (c == 7) ? 2 : 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "eos_n", int'(eos_n), 1);
    chk("R1", "mxc", int'(mxc), 0);
    chk("R1", "lchan", int'(lchan), 0);
    chk("R1", "start valid", int'(conv_start_valid), 0);
    chk("R1", "cal_active", int'(cal_active), 0);
    bread(adr(3, 3), d); chk("R1", "result zero", d, 0);
    bread(adr(2, 0), d); chk("R1", "control word", d, 7);

    for (int c = 0; c < 8; c++) wr_cfg(c);

    // sweep every active count with a permuted order
    for (int n = 1; n <= 8; n++) begin
      for (int s = 0; s < n; s++) begin
        lst[s] = (s * 3 + n) % 8;
        bwrite(adr(1, s), lst[s]);
      end
      bwrite(adr(2, 0), 256 + n - 1);
      bwrite(adr(2, 0), n - 1);
      for (int s = 0; s < n; s++)
        convert(s, lst[s], resval(n, s, lst[s]), s % 3, (s < n - 1) ? 1 : 0);
      chk("R12", "stopped after scan", int'(conv_start_valid), 0);
      chk("R8", "eos low at scan end", int'(eos_n), 0);
      for (int s = 0; s < n; s++) begin
        bread(adr(3, s), d);
        chk("R5", "stored result", d, resval(n, s, lst[s]));
        chk("R8", "eos after read", int'(eos_n), (s == n - 1) ? 1 : 0);
      end
    end

    // wrap, overwrite and deferred reprogramming
    bwrite(adr(1, 0), 5); bwrite(adr(1, 1), 2); bwrite(adr(1, 2), 7);
    bwrite(adr(2, 0), 256 + 1);
    convert(0, 5, resval(20, 0, 5), 0, 1);
    convert(1, 2, resval(20, 1, 2), 1, 1);
    chk("R7", "wrap to slot 0", int'(lchan), 0);
    chk("R8", "eos low", int'(eos_n), 0);
    bwrite(adr(2, 0), 256 + 2);
    convert(0, 5, resval(21, 0, 5), 0, 1);
    convert(1, 2, resval(21, 1, 2), 2, 1);
    chk("R10", "old count kept for running scan", int'(lchan), 0);
    chk("R9", "eos stays low", int'(eos_n), 0);
    bread(adr(3, 0), d);
    chk("R9", "overwritten result", d, resval(21, 0, 5));
    chk("R8", "non-last read keeps eos", int'(eos_n), 0);
    bwrite(adr(2, 0), 2);
    convert(0, 5, resval(22, 0, 5), 0, 1);
    convert(1, 2, resval(22, 1, 2), 0, 1);
    convert(2, 7, resval(22, 2, 7), 1, 0);
    chk("R10", "new count used next scan", int'(eos_n), 0);
    bread(adr(3, 1), d);
    chk("R8", "old last slot read keeps eos", int'(eos_n), 0);
    bread(adr(3, 2), d);
    chk("R5", "slot 2 result", d, resval(22, 2, 7));
    chk("R8", "last slot read releases eos", int'(eos_n), 1);

    // calibration indicator over active slots {5,2,7}
    repeat (3) @(negedge clk);
    chk("R11", "ch7 in calibration", int'(cal_active), 1);
    calc[7] = 0; wr_cfg(7);
    repeat (3) @(negedge clk);
    chk("R11", "none in calibration", int'(cal_active), 0);
    calc[6] = 1; wr_cfg(6);
    repeat (3) @(negedge clk);
    chk("R11", "inactive channel ignored", int'(cal_active), 0);
    calc[2] = 3; wr_cfg(2);
    repeat (3) @(negedge clk);
    chk("R11", "ch2 in calibration", int'(cal_active), 1);
    bwrite(adr(2, 0), 0);
    repeat (3) @(negedge clk);
    chk("R11", "slot 1 now inactive", int'(cal_active), 0);
    ch = 0;
    chk("R12", "idle without enable", int'(conv_start_valid), ch);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule